// File: doc/BRIEF.md
# Add-Shift Sequential Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns the full `2*WIDTH`-bit product. It uses one adder over many clocks and does not build a combinational array. A controller sequences a small datapath, which holds five pieces of state:

- an operand-B register;
- an upper accumulator;
- a lower register that first holds the multiplier and ends with the low half of the product;
- a one-bit carry stage;
- a down-counting bit counter.

The adder always forms the accumulator plus operand B. Its sum and carry-out are stored only when the controller issues an add command.

A start pulse in the idle state begins a run. The controller first loads the operands, clears the accumulator and the carry, and loads the counter. It then repeats one iteration per multiplier bit. The first cycle of an iteration adds operand B, but only if the current lowest multiplier bit is 1. The second cycle shifts the carry, the accumulator and the lower register right as one chain, and the counter steps down. When the counter runs out, a done pulse lasts one cycle and the controller returns to idle. The product is read from the product port, whose upper half is the accumulator. It holds its value until the next run is accepted.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `done` is 0 and `product` is all zeros.
- R2: A run started with operands `a` (multiplicand) and `b` (multiplier) leaves `product` equal to the unsigned value `a*b`, in `2*WIDTH` bits.
- R3: `done` is high for exactly one cycle. Count the rising edge that samples `start` as edge 0. `done` goes high after edge `2*WIDTH` and is low again after edge `2*WIDTH+1`.
- R4: After `done`, `product` keeps its value on every cycle until a new start is accepted.
- R5: `start` has no effect while a run is in progress. The operand inputs are sampled only on the edge that accepts `start`, so later changes to them change neither the result nor the timing.
- R6: Corner operands give correct products. These include 0, 1 and the all-ones value on either side, and all-ones times all-ones, whose adds produce carries.
- R7: The load step clears the accumulator and the carry. An add command occurs only when the lowest multiplier bit is 1. It loads the adder sum into the accumulator and the adder carry-out into the carry stage.
- R8: A shift command moves the chain carry, accumulator, lower register right by one place as a single register and fills the top with 0. At most one of the load, add and shift commands is active in any cycle.
- R9: The bit counter is loaded with `WIDTH`. It steps down by one on every shift and never steps below zero. The loop ends on the shift that brings it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| multiplicand | input | WIDTH | Operand a, sampled when a run is accepted |
| multiplier | input | WIDTH | Operand b, sampled when a run is accepted |
| product | output | 2*WIDTH | Accumulator (upper half) joined with the lower register |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The bench builds the block with `WIDTH = 4`. At that width the full operand space of 256 pairs can be swept, so every multiplier bit pattern and every carry-out case the adder can produce is exercised, including 15 times 15. For every pair, the bench checks the exact done latency of `2*WIDTH` edges and the product against arithmetic multiplication. After each done pulse, it also checks that the pulse drops and that the product holds. Throughout each run, the operand inputs are scrambled after the start edge. On runs where the low bit of a XOR b is 1, a stray start pulse is also injected mid-run, which tests that the block ignores both.

// File: rtl/mult_pkg.sv
package mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/mult_bitcnt.sv
module mult_bitcnt #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          last
);

  localparam logic [CW-1:0] LOAD_VAL = CW'(WIDTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= LOAD_VAL;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign last  = (cnt_q == CW'(1));

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == LOAD_VAL); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> count == $past(count) - 1'b1); // R9
  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> count != '0); // R9

endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_init,
  input  logic               cmd_add,
  input  logic               cmd_shift,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  output logic               low_bit,
  output logic [2*WIDTH-1:0] product
);

  localparam int CHAIN = 2 * WIDTH + 1;

  // Sum of accumulator and operand B, carry-out in the top bit.
  function automatic logic [WIDTH:0] acc_plus(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Logical right shift of the carry/accumulator/lower chain.
  function automatic logic [CHAIN-1:0] chain_right(input logic [CHAIN-1:0] v);
    return {1'b0, v[CHAIN-1:1]};
  endfunction

  logic [WIDTH-1:0] b_q, a_q, m_q;
  logic             c_q;
  logic [WIDTH:0]   adder_out;
  logic [CHAIN-1:0] chain_now, chain_next;

  assign adder_out  = acc_plus(a_q, b_q);
  assign chain_now  = {c_q, a_q, m_q};
  assign chain_next = chain_right(chain_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      a_q <= '0;
      m_q <= '0;
      c_q <= 1'b0;
    end else if (cmd_init) begin
      b_q <= opa;
      m_q <= opb;
      a_q <= '0;
      c_q <= 1'b0;
    end else if (cmd_add) begin
      c_q <= adder_out[WIDTH];
      a_q <= adder_out[WIDTH-1:0];
    end else if (cmd_shift) begin
      c_q <= chain_next[CHAIN-1];
      a_q <= chain_next[CHAIN-2 -: WIDTH];
      m_q <= chain_next[WIDTH-1:0];
    end
  end

  assign low_bit = m_q[0];
  assign product = {a_q, m_q};

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_init |=> (a_q == '0) && !c_q && (m_q == $past(opb)) && (b_q == $past(opa))); // R7
  AST_ADD_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_add && !cmd_init) |=> {c_q, a_q} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)})); // R7
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_shift && !cmd_init && !cmd_add) |=>
      ({c_q, a_q, m_q} == {1'b0, $past(c_q), $past(a_q), $past(m_q[WIDTH-1:1])})); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_init || cmd_add || cmd_shift) |=> $stable(product) && $stable(b_q)); // R4

endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic low_bit,
  input  logic cnt_last,
  output logic cmd_init,
  output logic cmd_add,
  output logic cmd_shift,
  output logic done,
  output logic busy
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cmd_init  = 1'b0;
    cmd_add   = 1'b0;
    cmd_shift = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cmd_init = 1'b1;
          state_d  = ST_TEST;
        end
      end
      ST_TEST: begin
        cmd_add = low_bit;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        cmd_shift = 1'b1;
        state_d   = cnt_last ? ST_DONE : ST_TEST;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_init, cmd_add, cmd_shift, done})); // R8
  AST_ADD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_add |-> low_bit); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_init); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R3
  AST_SHIFT_FOLLOWS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEST) |=> cmd_shift); // R8

endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  localparam int CW = $clog2(WIDTH) + 1;

  // Named internal events shared by the blocks and the assertions.
  logic          ev_init, ev_add, ev_shift, ev_busy;
  logic          low_bit, cnt_last;
  logic [CW-1:0] bit_count;

  mult_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .low_bit   (low_bit),
    .cnt_last  (cnt_last),
    .cmd_init  (ev_init),
    .cmd_add   (ev_add),
    .cmd_shift (ev_shift),
    .done      (done),
    .busy      (ev_busy)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_init  (ev_init),
    .cmd_add   (ev_add),
    .cmd_shift (ev_shift),
    .opa       (multiplicand),
    .opb       (multiplier),
    .low_bit   (low_bit),
    .product   (product)
  );

  mult_bitcnt #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_init),
    .dec   (ev_shift),
    .count (bit_count),
    .last  (cnt_last)
  );

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bit_count == '0); // R9
  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(product)); // R4
  AST_IDLE_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_busy |-> !ev_add && !ev_shift); // R5

endmodule

// File: tb/shiftadd_mult_bench.sv
`timescale 1ns/1ps
module shiftadd_mult_bench;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shiftadd_mult #(.WIDTH(W)) u_shiftadd_mult (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .product      (product),
    .done         (done)
  );

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int b, input bit busy_poke);
    int n;
    logic [2*W-1:0] expv;
    logic [2*W-1:0] held;
    string tag;
    expv = (2*W)'(a * b);
    tag = (a == 0 || b == 0 || a == 1 || b == 1 || a == (1<<W)-1 || b == (1<<W)-1)
          ? "R6 corner product" : "R2 R7 R8 product";
    mcand = W'(a);
    mplier = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R5: scramble operands after the accepting edge.
    mcand = ~W'(a);
    mplier = W'(b + 3);
    n = 0;
    while (!done && n < 4*W + 8) begin
      @(negedge clk);
      n++;
      if (busy_poke && n == 2) begin
        start = 1'b1;
        mcand = W'(a + 5);
      end
      if (busy_poke && n == 3) start = 1'b0;
    end
    check(n == 2*W, "R3 R9 done latency", n, 2*W);
    check(product == expv, busy_poke ? "R5 start ignored while busy" : tag,
          product, expv);
    held = product;
    @(negedge clk);
    check(done == 1'b0, "R3 done single cycle", done, 0);
    check(product == held, "R4 product held after done", product, held);
    @(negedge clk);
    check(product == held, "R4 product held while idle", product, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && product == '0, "R1 in reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(product == '0, "R1 product after reset", product, 0);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run(a, b, ((a ^ b) & 1) == 1);
      end
    end
    run((1 << W) - 1, (1 << W) - 1, 1'b0); // R6 repeated after a full sweep
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule